// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic stage of an 8-bit accumulator processor. The same stage also handles 16-bit add, subtract, compare and load. Each cycle the surrounding datapath may present two operands, an operation code and the current condition-code byte, with `in_valid` high. One clock later the block returns the result, the updated condition-code byte, a write strobe for the destination register, and six branch conditions decoded from the new flags.

The flags follow fixed rules. Subtraction reports a borrow in the carry flag. Half-carry is produced only by 8-bit additions. Logical and load operations clear the overflow flag. The multiply places bit 7 of its product in the carry flag. The three system bits (entire-state, fast-interrupt mask, interrupt mask) are never changed here. Instruction decoding, addressing and memory access are done elsewhere.

Top module: `acc_alu`

## Requirements
- R1: After reset, `result`, `cc_out`, `wr_en` and `out_valid` are zero. An operation accepted with `in_valid` high at one rising edge shows its outputs from that edge on, with `out_valid` high.
- R2: Codes 0 (add) and 1 (add with carry-in from C) operate on the low bytes. They set C to the carry out of bit 7, H (bit 5) to bit 4 of a^b^result, V to the signed overflow, and N and Z from the 8-bit result.
- R3: Codes 2 (subtract), 3 (subtract with borrow-in from C) and 10 (negate, 0 - a) set C when a borrow leaves bit 7, V on signed overflow, and N and Z from the result. They leave H unchanged.
- R4: Codes 4 (8-bit compare) and 21 (16-bit compare) produce the same flags and result as the matching subtract but hold `wr_en` low. All other defined codes raise `wr_en`.
- R5: Codes 5 (AND), 6 (OR), 7 (XOR) and 8 (8-bit load, passes b) set N and Z, clear V and keep C. Code 22 (16-bit load, passes b) does the same using bit 15 for N.
- R6: Code 9 (complement) clears V and sets C. Codes 11 and 12 (increment, decrement) set V on signed overflow and keep C. Codes 13 (shift left), 14 (arithmetic shift right), 15 (logical shift right), 16 (rotate left through C) and 17 (rotate right through C) load C with the bit shifted out. Left moves set V to bit7^bit6 of a, right moves keep V, and all five set N and Z.
- R7: Code 18 multiplies the low bytes into a 16-bit product. It sets Z when the product is zero and C to bit 7 of the product, and keeps N and V.
- R8: Codes 19 (add) and 20 (subtract) work on 16 bits, with C as carry or borrow out of bit 15, V on signed overflow, N from bit 15 and Z on a zero word. They leave H unchanged.
- R9: Bits 7 (E), 6 (F) and 4 (I) of `cc_out` always equal the same bits of the accepted `cc_in`. H changes only on codes 0 and 1. Flag positions are C=0, V=1, Z=2, N=3.
- R10: The branch outputs follow the flags in `cc_out`: ls=C|Z, hi=!(C|Z), lt=N^V, ge=!(N^V), le=Z|(N^V), gt=!(Z|(N^V)).
- R11: A cycle with `in_valid` low leaves `result` and `cc_out` unchanged and drives `wr_en` and `out_valid` low.
- R12: Every 8-bit operation (codes 0 to 17) returns zero in `result[15:8]`.
- R13: Codes 23 to 31 hold `wr_en` low, return a zero result and pass `cc_in` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| opnd_a | input | 16 | First operand (low byte for 8-bit operations) |
| opnd_b | input | 16 | Second operand (low byte for 8-bit operations) |
| cc_in | input | 8 | Current condition-code byte |
| result | output | 16 | Registered result |
| cc_out | output | 8 | Registered updated condition codes |
| wr_en | output | 1 | Result should be written to the destination |
| out_valid | output | 1 | Outputs belong to an operation accepted last edge |
| br_ls | output | 1 | Lower or same |
| br_hi | output | 1 | Higher |
| br_lt | output | 1 | Less than (signed) |
| br_ge | output | 1 | Greater or equal (signed) |
| br_le | output | 1 | Less or equal (signed) |
| br_gt | output | 1 | Greater than (signed) |

## Verification
The hardest cases to reach are the flag boundaries where two carry chains disagree: signed overflow at 0x7F+1 and 0x80-1, carry without overflow at 0xFF+1, borrow at 0-1, and their 16-bit counterparts. Random operands hit these only rarely, so a directed vector table drives each of them with chosen incoming flags, including set system bits and a set carry feeding the with-carry forms. Random operand pairs for every code, including the unused ones, are then compared against a reference model that works out overflow from signed integer ranges rather than from carry bits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CC_W   = 8;
    localparam int MSB8   = BYTE_W - 1;
    localparam int MSB16  = WORD_W - 1;
    localparam int OP_W   = 5;

    // flag positions inside the condition-code byte
    localparam int CC_C = 0;
    localparam int CC_V = 1;
    localparam int CC_Z = 2;
    localparam int CC_N = 3;
    localparam int CC_I = 4;
    localparam int CC_H = 5;
    localparam int CC_F = 6;
    localparam int CC_E = 7;

    typedef enum logic [OP_W-1:0] {
        OP_ADD8  = 5'd0,  OP_ADC8  = 5'd1,  OP_SUB8  = 5'd2,  OP_SBC8  = 5'd3,
        OP_CMP8  = 5'd4,  OP_AND8  = 5'd5,  OP_OR8   = 5'd6,  OP_XOR8  = 5'd7,
        OP_LD8   = 5'd8,  OP_COM8  = 5'd9,  OP_NEG8  = 5'd10, OP_INC8  = 5'd11,
        OP_DEC8  = 5'd12, OP_ASL8  = 5'd13, OP_ASR8  = 5'd14, OP_LSR8  = 5'd15,
        OP_ROL8  = 5'd16, OP_ROR8  = 5'd17, OP_MUL   = 5'd18, OP_ADD16 = 5'd19,
        OP_SUB16 = 5'd20, OP_CMP16 = 5'd21, OP_LD16  = 5'd22
    } alu_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [CC_W-1:0]   cc;
        logic              wr;
        logic              done;
    } alu_state_t;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic [W-1:0] cvec,
    output logic         co,
    output logic         ov
);
    logic [W-1:0] y_eff;
    logic [W:0]   sum;

    always_comb begin
        y_eff = sub ? ~y : y;
        // subtract: x + ~y + ~borrow_in ; carry-out inverted gives borrow
        sum   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, ci ^ sub};
        r     = sum[W-1:0];
        co    = sum[W] ^ sub;
        cvec  = x ^ y ^ r;           // carry/borrow into each bit position
        ov    = cvec[W-1] ^ co;
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [CC_W-1:0]   cc,
    output logic [WORD_W-1:0] res,
    output logic [CC_W-1:0]   cc_nx,
    output logic              wr
);
    logic [BYTE_W-1:0] a8, b8;
    logic [BYTE_W-1:0] s_x, s_y;
    logic              s_ci, s_sub;
    logic [BYTE_W-1:0] r8, cv8;
    logic              c8, v8;
    logic              sub16;
    logic [WORD_W-1:0] r16, cv16;
    logic              c16, v16;
    logic [WORD_W-1:0] prod;
    logic [BYTE_W-1:0] res8;
    logic              set_nz8;

    assign a8 = a[MSB8:0];
    assign b8 = b[MSB8:0];

    // operand steering for the shared byte adder
    always_comb begin
        s_x   = a8;
        s_y   = b8;
        s_ci  = 1'b0;
        s_sub = 1'b0;
        unique case (op)
            OP_ADC8: s_ci = cc[CC_C];
            OP_SUB8, OP_CMP8: s_sub = 1'b1;
            OP_SBC8: begin s_sub = 1'b1; s_ci = cc[CC_C]; end
            OP_NEG8: begin s_x = '0; s_y = a8; s_sub = 1'b1; end
            OP_INC8: s_y = BYTE_W'(1);
            OP_DEC8: begin s_y = BYTE_W'(1); s_sub = 1'b1; end
            default: ;
        endcase
    end

    acc_alu_addsub #(.W(BYTE_W)) u_add8 (
        .x(s_x), .y(s_y), .ci(s_ci), .sub(s_sub),
        .r(r8), .cvec(cv8), .co(c8), .ov(v8)
    );

    assign sub16 = (op == OP_SUB16) || (op == OP_CMP16);

    acc_alu_addsub #(.W(WORD_W)) u_add16 (
        .x(a), .y(b), .ci(1'b0), .sub(sub16),
        .r(r16), .cvec(cv16), .co(c16), .ov(v16)
    );

    assign prod = {{BYTE_W{1'b0}}, a8} * {{BYTE_W{1'b0}}, b8};

    always_comb begin
        cc_nx   = cc;
        res     = '0;
        wr      = 1'b1;
        res8    = '0;
        set_nz8 = 1'b0;
        unique case (op)
            OP_ADD8, OP_ADC8: begin
                res8 = r8; set_nz8 = 1'b1;
                cc_nx[CC_C] = c8;
                cc_nx[CC_V] = v8;
                cc_nx[CC_H] = cv8[4];
            end
            OP_SUB8, OP_SBC8, OP_CMP8, OP_NEG8: begin
                res8 = r8; set_nz8 = 1'b1;
                cc_nx[CC_C] = c8;
                cc_nx[CC_V] = v8;
                wr = (op != OP_CMP8);
            end
            OP_INC8, OP_DEC8: begin
                res8 = r8; set_nz8 = 1'b1;
                cc_nx[CC_V] = v8;
            end
            OP_AND8, OP_OR8, OP_XOR8, OP_LD8: begin
                unique case (op)
                    OP_AND8: res8 = a8 & b8;
                    OP_OR8:  res8 = a8 | b8;
                    OP_XOR8: res8 = a8 ^ b8;
                    default: res8 = b8;
                endcase
                set_nz8 = 1'b1;
                cc_nx[CC_V] = 1'b0;
            end
            OP_COM8: begin
                res8 = ~a8; set_nz8 = 1'b1;
                cc_nx[CC_V] = 1'b0;
                cc_nx[CC_C] = 1'b1;
            end
            OP_ASL8, OP_ROL8: begin
                res8 = {a8[MSB8-1:0], (op == OP_ROL8) ? cc[CC_C] : 1'b0};
                set_nz8 = 1'b1;
                cc_nx[CC_C] = a8[MSB8];
                cc_nx[CC_V] = a8[MSB8] ^ a8[MSB8-1];
            end
            OP_ASR8, OP_LSR8, OP_ROR8: begin
                unique case (op)
                    OP_ASR8: res8 = {a8[MSB8], a8[MSB8:1]};
                    OP_LSR8: res8 = {1'b0, a8[MSB8:1]};
                    default: res8 = {cc[CC_C], a8[MSB8:1]};
                endcase
                set_nz8 = 1'b1;
                cc_nx[CC_C] = a8[0];
            end
            OP_MUL: begin
                res = prod;
                cc_nx[CC_Z] = (prod == '0);
                cc_nx[CC_C] = prod[MSB8];
            end
            OP_ADD16, OP_SUB16, OP_CMP16: begin
                res = r16;
                cc_nx[CC_N] = r16[MSB16];
                cc_nx[CC_Z] = (r16 == '0);
                cc_nx[CC_V] = v16;
                cc_nx[CC_C] = c16;
                wr = (op != OP_CMP16);
            end
            OP_LD16: begin
                res = b;
                cc_nx[CC_N] = b[MSB16];
                cc_nx[CC_Z] = (b == '0);
                cc_nx[CC_V] = 1'b0;
            end
            default: wr = 1'b0;
        endcase
        if (set_nz8) begin
            res = {{BYTE_W{1'b0}}, res8};
            cc_nx[CC_N] = res8[MSB8];
            cc_nx[CC_Z] = (res8 == '0);
        end
    end

    // R9: the half-carry flag moves only on byte additions
    always_comb begin
        if (op != OP_ADD8 && op != OP_ADC8)
            a_r9_h_only_add8: assert (cc_nx[CC_H] == cc[CC_H]);
    end
endmodule

// File: rtl/acc_alu_cond.sv
module acc_alu_cond
    import acc_alu_pkg::*;
(
    input  logic [CC_W-1:0] cc,
    output logic            ls,
    output logic            hi,
    output logic            lt,
    output logic            ge,
    output logic            le,
    output logic            gt
);
    logic [CC_W-1:0] unused_bits;
    assign unused_bits = cc;

    always_comb begin
        ls = cc[CC_C] | cc[CC_Z];
        hi = ~ls;
        lt = cc[CC_N] ^ cc[CC_V];
        ge = ~lt;
        le = cc[CC_Z] | lt;
        gt = ~le;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [CC_W-1:0]   cc_in,
    output logic [WORD_W-1:0] result,
    output logic [CC_W-1:0]   cc_out,
    output logic              wr_en,
    output logic              out_valid,
    output logic              br_ls,
    output logic              br_hi,
    output logic              br_lt,
    output logic              br_ge,
    output logic              br_le,
    output logic              br_gt
);
    alu_state_t        st_d, st_q;
    logic [WORD_W-1:0] core_res;
    logic [CC_W-1:0]   core_cc;
    logic              core_wr;

    acc_alu_core u_core (
        .op(alu_op_e'(op_code)), .a(opnd_a), .b(opnd_b), .cc(cc_in),
        .res(core_res), .cc_nx(core_cc), .wr(core_wr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        st_d.done = 1'b0;
        if (in_valid) begin
            st_d.res  = core_res;
            st_d.cc   = core_cc;
            st_d.wr   = core_wr;
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result    = st_q.res;
    assign cc_out    = st_q.cc;
    assign wr_en     = st_q.wr;
    assign out_valid = st_q.done;

    acc_alu_cond u_cond (
        .cc(st_q.cc), .ls(br_ls), .hi(br_hi), .lt(br_lt),
        .ge(br_ge), .le(br_le), .gt(br_gt)
    );

    // R4: compares never request a write
    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == OP_CMP8 || op_code == OP_CMP16)) |=> !wr_en);

    // R9: system bits pass through untouched
    a_r9_sys_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cc_out[CC_E] == $past(cc_in[CC_E]) &&
                      cc_out[CC_F] == $past(cc_in[CC_F]) &&
                      cc_out[CC_I] == $past(cc_in[CC_I])));

    // R5: logical and load operations clear overflow
    a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code >= OP_AND8 && op_code <= OP_LD8 || op_code == OP_LD16))
        |=> !cc_out[CC_V]);

    // R7: multiply carry mirrors bit 7 of the product
    a_r7_mul_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == OP_MUL) |=> (cc_out[CC_C] == result[MSB8]));

    // R11: idle cycles hold the outputs and drop the strobes
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !out_valid && $stable(result) && $stable(cc_out)));

    // R12: byte operations clear the upper result byte
    a_r12_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code <= OP_ROR8) |=> (result[MSB16:BYTE_W] == '0));
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [7:0]  cc_in = '0;
    logic [15:0] result;
    logic [7:0]  cc_out;
    logic        wr_en, out_valid;
    logic        br_ls, br_hi, br_lt, br_ge, br_le, br_gt;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cc_in(cc_in),
        .result(result), .cc_out(cc_out), .wr_en(wr_en), .out_valid(out_valid),
        .br_ls(br_ls), .br_hi(br_hi), .br_lt(br_lt),
        .br_ge(br_ge), .br_le(br_le), .br_gt(br_gt)
    );

    typedef struct packed {
        logic [4:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [7:0]  cc;
        logic [15:0] er;
        logic [7:0]  ecc;
        logic        ew;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{5'd0,  16'h007F, 16'h0001, 8'h00, 16'h0080, 8'h2A, 1'b1}, // R2 0x7F+1
        '{5'd2,  16'h0080, 16'h0001, 8'h00, 16'h007F, 8'h02, 1'b1}, // R3 0x80-1
        '{5'd0,  16'h00FF, 16'h0001, 8'h00, 16'h0000, 8'h25, 1'b1}, // R2 0xFF+1
        '{5'd2,  16'h0000, 16'h0001, 8'h00, 16'h00FF, 8'h09, 1'b1}, // R3 0-1
        '{5'd4,  16'h0005, 16'h0005, 8'hD0, 16'h0000, 8'hD4, 1'b0}, // R4
        '{5'd1,  16'h000F, 16'h0000, 8'h01, 16'h0010, 8'h20, 1'b1}, // R2 carry-in
        '{5'd3,  16'h0010, 16'h000F, 8'h01, 16'h0000, 8'h04, 1'b1}, // R3 borrow-in
        '{5'd5,  16'h00F0, 16'h003C, 8'h03, 16'h0030, 8'h01, 1'b1}, // R5
        '{5'd9,  16'h0000, 16'h0000, 8'h00, 16'h00FF, 8'h09, 1'b1}, // R6 COM
        '{5'd10, 16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B, 1'b1}, // R3 NEG
        '{5'd13, 16'h00C0, 16'h0000, 8'h00, 16'h0080, 8'h09, 1'b1}, // R6 ASL
        '{5'd17, 16'h0001, 16'h0000, 8'h01, 16'h0080, 8'h09, 1'b1}, // R6 ROR
        '{5'd18, 16'h00FF, 16'h00FF, 8'h0A, 16'hFE01, 8'h0A, 1'b1}, // R7
        '{5'd19, 16'h7FFF, 16'h0001, 8'h20, 16'h8000, 8'h2A, 1'b1}, // R8
        '{5'd20, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h09, 1'b1}, // R8
        '{5'd21, 16'h1234, 16'h1234, 8'h00, 16'h0000, 8'h04, 1'b0}, // R4
        '{5'd15, 16'h0001, 16'h0000, 8'h08, 16'h0000, 8'h05, 1'b1}, // R6 LSR
        '{5'd11, 16'h007F, 16'h0000, 8'h01, 16'h0080, 8'h0B, 1'b1}, // R6 INC
        '{5'd12, 16'h0080, 16'h0000, 8'h00, 16'h007F, 8'h02, 1'b1}, // R6 DEC
        '{5'd22, 16'h0000, 16'h8000, 8'h02, 16'h8000, 8'h08, 1'b1}  // R5 LD16
    };

    function automatic string req_of(int op);
        if (op <= 1 || op == 0)           return "R2";
        if (op == 2 || op == 3 || op == 10) return "R3";
        if (op == 4 || op == 21)          return "R4";
        if ((op >= 5 && op <= 8) || op == 22) return "R5";
        if (op == 18)                     return "R7";
        if (op == 19 || op == 20)         return "R8";
        if (op >= 23)                     return "R13";
        return "R6";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // independent reference: overflow from signed ranges, carries from integer sums
    task automatic ref_alu(input int op, input logic [15:0] a, input logic [15:0] b,
                           input logic [7:0] cc, output logic [15:0] r,
                           output logic [7:0] nc, output logic w);
        int ua = int'(a[7:0]);
        int ub = int'(b[7:0]);
        int sa = int'($signed(a[7:0]));
        int sb = int'($signed(b[7:0]));
        int ci = int'(cc[0]);
        int t = 0;
        int s = 0;
        bit set_nz = 1;
        bit wide = 0;
        nc = cc; w = 1; r = 0;
        case (op)
            0, 1: begin
                if (op == 0) ci = 0;
                t = ua + ub + ci; s = sa + sb + ci;
                nc[0] = t > 255; nc[1] = (s > 127 || s < -128);
                nc[5] = ((ua % 16) + (ub % 16) + ci) > 15;
            end
            2, 3, 4: begin
                if (op != 3) ci = 0;
                t = ua - ub - ci; s = sa - sb - ci;
                nc[0] = t < 0; nc[1] = (s > 127 || s < -128);
                w = (op != 4);
            end
            10: begin t = -ua; s = -sa; nc[0] = t < 0; nc[1] = s > 127; end
            11: begin t = ua + 1; nc[1] = (sa + 1) > 127; end
            12: begin t = ua - 1; nc[1] = (sa - 1) < -128; end
            5: begin t = ua & ub; nc[1] = 0; end
            6: begin t = ua | ub; nc[1] = 0; end
            7: begin t = ua ^ ub; nc[1] = 0; end
            8: begin t = ub; nc[1] = 0; end
            9: begin t = 255 - ua; nc[1] = 0; nc[0] = 1; end
            13, 16: begin
                t = ua * 2 + ((op == 16) ? ci : 0);
                nc[0] = ua >= 128;
                nc[1] = (ua >= 128) != ((ua % 128) >= 64);
            end
            14: begin t = ua / 2 + ((ua >= 128) ? 128 : 0); nc[0] = ua[0]; end
            15: begin t = ua / 2; nc[0] = ua[0]; end
            17: begin t = ua / 2 + ci * 128; nc[0] = ua[0]; end
            18: begin
                t = ua * ub; set_nz = 0; wide = 1;
                nc[2] = (t == 0); nc[0] = t[7];
            end
            19, 20, 21: begin
                int u1 = int'(a);
                int u2 = int'(b);
                int s1 = int'($signed(a));
                int s2 = int'($signed(b));
                wide = 1;
                if (op == 19) begin t = u1 + u2; s = s1 + s2; nc[0] = t > 65535; end
                else begin t = u1 - u2; s = s1 - s2; nc[0] = t < 0; end
                nc[1] = (s > 32767 || s < -32768);
                w = (op != 21);
            end
            22: begin t = int'(b); wide = 1; nc[1] = 0; end
            default: begin w = 0; set_nz = 0; end
        endcase
        if (op <= 17) begin
            r = {8'h00, t[7:0]};
            nc[3] = t[7]; nc[2] = (t[7:0] == 0);
        end else if (wide) begin
            r = t[15:0];
            if (set_nz) begin nc[3] = t[15]; nc[2] = (t[15:0] == 0); end
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic [15:0] a,
                         input logic [15:0] b, input logic [7:0] cc);
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; cc_in = cc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_out(int op, logic [15:0] er, logic [7:0] ecc, logic ew);
        logic c = ecc[0], v = ecc[1], z = ecc[2], n = ecc[3];
        check({req_of(op), " result"}, 32'(result), 32'(er));
        check({req_of(op), " flags"}, 32'(cc_out), 32'(ecc));
        check({req_of(op), " write"}, 32'(wr_en), 32'(ew));
        check("R1 out_valid", 32'(out_valid), 32'd1);
        check("R9 system bits", 32'({cc_out[7], cc_out[6], cc_out[4]}),
              32'({cc_in[7], cc_in[6], cc_in[4]}));
        if (op <= 17) check("R12 upper byte", 32'(result[15:8]), 32'd0);
        check("R10 branch conditions",
              32'({br_ls, br_hi, br_lt, br_ge, br_le, br_gt}),
              32'({c | z, !(c | z), n ^ v, !(n ^ v), z | (n ^ v), !(z | (n ^ v))}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset result", 32'(result), 32'd0);
        check("R1 reset flags", 32'(cc_out), 32'd0);
        check("R1 reset strobes", 32'({wr_en, out_valid}), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].cc);
            check_out(int'(VEC[i].op), VEC[i].er, VEC[i].ecc, VEC[i].ew);
        end

        // R11: idle cycle after an operation keeps result and flags
        apply(5'd0, 16'h0011, 16'h0022, 8'h50);
        @(negedge clk);
        check("R11 idle result", 32'(result), 32'h0033);
        check("R11 idle flags", 32'(cc_out), 32'h50);
        check("R11 idle strobes", 32'({wr_en, out_valid}), 32'd0);

        // R13: unused code passes flags, no write
        apply(5'd27, 16'h1234, 16'h5678, 8'hA5);
        check("R13 unused result", 32'(result), 32'd0);
        check("R13 unused flags", 32'(cc_out), 32'hA5);
        check("R13 unused write", 32'(wr_en), 32'd0);

        // random operands for every code against the reference model
        for (int op = 0; op < 32; op++) begin
            for (int k = 0; k < 60; k++) begin
                logic [15:0] ra = 16'($urandom);
                logic [15:0] rb = 16'($urandom);
                logic [7:0]  rc = 8'($urandom);
                logic [15:0] er;
                logic [7:0]  ecc;
                logic        ew;
                ref_alu(op, ra, rb, rc, er, ecc, ew);
                apply(5'(op), ra, rb, rc);
                check_out(op, er, ecc, ew);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule